// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This unit turns a stream of time-quantum ticks into the bit grid of a CAN node. Every nominal bit is built from a one-quantum sync segment, a first phase segment that ends at the sample point, and a second phase segment that ends at the transmit point. When the sample point is reached the unit pulses a strobe together with the receive-line value seen on that quantum. When the transmit point is reached it pulses a second strobe.

The unit aligns itself to the bus by watching recessive-to-dominant transitions on the receive line. These transitions are sampled only on quantum ticks. While the frame logic reports the bus as idle, such a transition forces a hard synchronization, and the bit restarts at once. At other times a transition that comes after the sync segment stretches the first segment. A transition that falls in the second segment is taken as the early start of the next bit, and the second segment is cut short. Each correction is capped by the programmed jump width, and only one correction is applied between two sample points. The tick prescaler, bit stuffing and frame decoding sit outside this unit.

Top module: `can_bit_timing`

## Requirements
- R1: After reset, both strobes are low, the sampled-bit output is 1 (recessive), and the first quantum tick is treated as the sync segment.
- R2: The configuration fields hold lengths minus one. A field value v gives v+1 quanta for segment 1 (4-bit field), segment 2 (3-bit field) and the jump width (2-bit field).
- R3: With no bus edges, a bit lasts 1 + seg1 + seg2 quanta. The sample strobe follows the tick that ends quantum 1+seg1 of the bit, and the transmit strobe follows the tick that ends the last quantum.
- R4: The sampled-bit output changes only together with a sample strobe, and it then equals the receive-line value seen on that tick.
- R5: While idle is high, a falling edge seen on a tick makes that quantum the sync segment of a new bit, in any phase. If the unit was in segment 2, a transmit strobe is issued on the same tick.
- R6: A falling edge on the k-th quantum of segment 1 (k counted from 0), when not idle, lengthens segment 1 of that bit by min(k+1, jump width).
- R7: A falling edge on quantum k of segment 2, with r = remaining segment-2 quanta counted from k: if r ≤ jump width, a transmit strobe is issued on that tick and that quantum becomes the sync segment of the next bit. Otherwise segment 2 is shortened by the jump width.
- R8: A falling edge that falls in the sync segment does not change the bit timing.
- R9: After a correction, further falling edges are ignored until the next sample strobe.
- R10: Rising (dominant-to-recessive) edges never change the bit timing.
- R11: Strobes appear only in the cycle after a tick. Changes on the receive line between ticks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tq_tick_i | input | 1 | One-cycle pulse marking the end of each time quantum |
| rx_i | input | 1 | Synchronized receive line (1 = recessive) |
| idle_i | input | 1 | High while the frame logic awaits a start-of-frame edge |
| bs1_cfg_i | input | 4 | Segment-1 length minus one |
| bs2_cfg_i | input | 3 | Segment-2 length minus one |
| sjw_cfg_i | input | 2 | Jump width minus one |
| sample_o | output | 1 | Sample-point strobe |
| sample_bit_o | output | 1 | Receive value taken at the last sample point |
| tx_pt_o | output | 1 | Transmit-point strobe |

## Verification
The assertions assume that a tick is a single-cycle pulse and that the receive line is stable across each tick cycle. The bench drives ticks one cycle wide, spaced four clocks apart, and changes the receive line only on falling clock edges. Between ticks it also toggles the line and restores it, so that ignored edges are exercised. The configuration is changed only while the unit is held in reset, so every bit in a scenario uses one set of lengths. Expected sample and transmit positions are computed from the programmed lengths and from the quantum on which each edge is placed.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
    localparam int BS1_W  = 4;
    localparam int BS2_W  = 3;
    localparam int SJW_W  = 2;
    localparam int JMP_W  = SJW_W + 1;
    localparam int LIM1_W = $clog2((1 << BS1_W) + (1 << SJW_W) + 1);
    localparam int LIM2_W = $clog2((1 << BS2_W) + 1);
    localparam int CNT_W  = LIM1_W;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_SEG1 = 2'd1,
        PH_SEG2 = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [LIM1_W-1:0]   lim1;
        logic [LIM2_W-1:0]   lim2;
        logic                rs_done;
        logic                prev_rx;
        logic                smp;
        logic                smp_bit;
        logic                txp;
    } bt_state_t;
endpackage

// File: rtl/can_bt_edge.sv
module can_bt_edge (
    input  logic tick_i,
    input  logic rx_i,
    input  logic prev_i,
    output logic fall_o
);
    // recessive-to-dominant transition seen on a quantum boundary
    always_comb fall_o = tick_i & prev_i & ~rx_i;
endmodule

// File: rtl/can_bt_nom.sv
module can_bt_nom
    import can_bt_pkg::*;
(
    input  logic [BS1_W-1:0]  bs1_cfg_i,
    input  logic [BS2_W-1:0]  bs2_cfg_i,
    output logic [LIM1_W-1:0] lim1_o,
    output logic [LIM2_W-1:0] lim2_o
);
    // 0-based fields expand to real quantum counts
    always_comb begin
        lim1_o = LIM1_W'(bs1_cfg_i) + LIM1_W'(1);
        lim2_o = LIM2_W'(bs2_cfg_i) + LIM2_W'(1);
    end
endmodule

// File: rtl/can_bt_perr.sv
module can_bt_perr
    import can_bt_pkg::*;
(
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [LIM2_W-1:0] lim2_i,
    input  logic [SJW_W-1:0]  sjw_cfg_i,
    output logic [JMP_W-1:0]  grow_o,
    output logic              cut_o,
    output logic [LIM2_W-1:0] lim2_short_o
);
    logic [JMP_W-1:0]  jump;
    logic [CNT_W:0]    late_err;
    logic [LIM2_W-1:0] remain;

    always_comb begin
        jump     = JMP_W'(sjw_cfg_i) + JMP_W'(1);
        // late edge: quanta elapsed since the sync segment
        late_err = (CNT_W+1)'(cnt_i) + (CNT_W+1)'(1);
        if (late_err > (CNT_W+1)'(jump))
            grow_o = jump;
        else
            grow_o = late_err[JMP_W-1:0];
        // early edge: quanta still left in segment 2, this one included
        remain       = lim2_i - cnt_i[LIM2_W-1:0];
        cut_o        = (remain <= LIM2_W'(jump));
        lim2_short_o = lim2_i - LIM2_W'(jump);
    end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
    import can_bt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tq_tick_i,
    input  logic             rx_i,
    input  logic             idle_i,
    input  logic [BS1_W-1:0] bs1_cfg_i,
    input  logic [BS2_W-1:0] bs2_cfg_i,
    input  logic [SJW_W-1:0] sjw_cfg_i,
    output logic             sample_o,
    output logic             sample_bit_o,
    output logic             tx_pt_o
);
    bt_state_t st_d, st_q;

    logic              fall;
    logic [LIM1_W-1:0] lim1_nom;
    logic [LIM2_W-1:0] lim2_nom;
    logic [JMP_W-1:0]  grow;
    logic              cut;
    logic [LIM2_W-1:0] lim2_short;
    logic              resync;
    logic [LIM1_W-1:0] lim1_eff;
    logic [LIM2_W-1:0] lim2_eff;

    can_bt_edge u_edge (
        .tick_i (tq_tick_i),
        .rx_i   (rx_i),
        .prev_i (st_q.prev_rx),
        .fall_o (fall)
    );

    can_bt_nom u_nom (
        .bs1_cfg_i (bs1_cfg_i),
        .bs2_cfg_i (bs2_cfg_i),
        .lim1_o    (lim1_nom),
        .lim2_o    (lim2_nom)
    );

    can_bt_perr u_perr (
        .cnt_i        (st_q.cnt),
        .lim2_i       (st_q.lim2),
        .sjw_cfg_i    (sjw_cfg_i),
        .grow_o       (grow),
        .cut_o        (cut),
        .lim2_short_o (lim2_short)
    );

    always_comb begin
        st_d     = st_q;
        st_d.smp = 1'b0;
        st_d.txp = 1'b0;
        resync   = fall & ~st_q.rs_done & ~idle_i;
        lim1_eff = st_q.lim1;
        lim2_eff = st_q.lim2;

        if (tq_tick_i) begin
            st_d.prev_rx = rx_i;
            if (fall && idle_i) begin
                // hard sync: this quantum becomes the sync segment
                st_d.txp     = (st_q.ph == PH_SEG2);
                st_d.ph      = PH_SEG1;
                st_d.cnt     = '0;
                st_d.lim1    = lim1_nom;
                st_d.lim2    = lim2_nom;
                st_d.rs_done = 1'b1;
            end else begin
                unique case (st_q.ph)
                    PH_SYNC: begin
                        st_d.ph   = PH_SEG1;
                        st_d.cnt  = '0;
                        st_d.lim1 = lim1_nom;
                        st_d.lim2 = lim2_nom;
                    end
                    PH_SEG1: begin
                        if (resync) begin
                            lim1_eff     = st_q.lim1 + LIM1_W'(grow);
                            st_d.rs_done = 1'b1;
                        end
                        st_d.lim1 = lim1_eff;
                        if (st_q.cnt + CNT_W'(1) == CNT_W'(lim1_eff)) begin
                            st_d.smp     = 1'b1;
                            st_d.smp_bit = rx_i;
                            st_d.ph      = PH_SEG2;
                            st_d.cnt     = '0;
                            st_d.rs_done = 1'b0;
                        end else begin
                            st_d.cnt = st_q.cnt + CNT_W'(1);
                        end
                    end
                    PH_SEG2: begin
                        if (resync && cut) begin
                            // early edge close to the end: start next bit now
                            st_d.txp     = 1'b1;
                            st_d.ph      = PH_SEG1;
                            st_d.cnt     = '0;
                            st_d.lim1    = lim1_nom;
                            st_d.lim2    = lim2_nom;
                            st_d.rs_done = 1'b1;
                        end else begin
                            if (resync) begin
                                lim2_eff     = lim2_short;
                                st_d.rs_done = 1'b1;
                            end
                            st_d.lim2 = lim2_eff;
                            if (st_q.cnt + CNT_W'(1) == CNT_W'(lim2_eff)) begin
                                st_d.txp = 1'b1;
                                st_d.ph  = PH_SYNC;
                                st_d.cnt = '0;
                            end else begin
                                st_d.cnt = st_q.cnt + CNT_W'(1);
                            end
                        end
                    end
                    default: begin
                        st_d.ph  = PH_SYNC;
                        st_d.cnt = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ph      <= PH_SYNC;
            st_q.cnt     <= '0;
            st_q.lim1    <= '0;
            st_q.lim2    <= '0;
            st_q.rs_done <= 1'b0;
            st_q.prev_rx <= 1'b1;
            st_q.smp     <= 1'b0;
            st_q.smp_bit <= 1'b1;
            st_q.txp     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o     = st_q.smp;
    assign sample_bit_o = st_q.smp_bit;
    assign tx_pt_o      = st_q.txp;
endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic tq_tick_i,
    input logic rx_i,
    input logic sample_o,
    input logic sample_bit_o,
    input logic tx_pt_o
);
    logic want_tx;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       want_tx <= 1'b0;
        else if (sample_o) want_tx <= 1'b1;
        else if (tx_pt_o)  want_tx <= 1'b0;
    end

    // R11
    strobe_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o || tx_pt_o) |-> $past(tq_tick_i));

    // R3
    strobes_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sample_o && tx_pt_o));

    // R3
    sample_alternates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> !want_tx);

    // R7
    tx_alternates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_pt_o |-> want_tx);

    // R4
    sample_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> (sample_bit_o == $past(rx_i)));

    // R4
    bit_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sample_o |-> $stable(sample_bit_o));
endmodule

bind can_bit_timing can_bit_timing_chk u_chk (.*);

// File: tb/tb_can_bit_timing.sv
module tb_can_bit_timing;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       tq_tick_i = 1'b0;
    logic       rx_i = 1'b1;
    logic       idle_i = 1'b0;
    logic [3:0] bs1_cfg_i = 4'd5;
    logic [2:0] bs2_cfg_i = 3'd2;
    logic [1:0] sjw_cfg_i = 2'd1;
    logic       sample_o, sample_bit_o, tx_pt_o;

    int n_vec = 0;
    int n_bad = 0;
    int stray = 0;

    can_bit_timing dut (.*);

    always #10 clk_i = ~clk_i;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] b1, input logic [2:0] b2, input logic [1:0] sj,
                            input logic idl);
        @(negedge clk_i);
        rst_ni = 1'b0; tq_tick_i = 1'b0; rx_i = 1'b1;
        bs1_cfg_i = b1; bs2_cfg_i = b2; sjw_cfg_i = sj; idle_i = idl;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    // one quantum: tick with rx_v, observe strobes, then a gap with a glitch
    task automatic step(input logic rx_v, output logic s, output logic t, output logic b);
        @(negedge clk_i);
        tq_tick_i = 1'b1; rx_i = rx_v;
        @(negedge clk_i);
        tq_tick_i = 1'b0;
        s = sample_o; t = tx_pt_o; b = sample_bit_o;
        rx_i = ~rx_v;
        @(negedge clk_i);
        if (sample_o || tx_pt_o) stray++;
        rx_i = rx_v;
        @(negedge clk_i);
        if (sample_o || tx_pt_o) stray++;
    endtask

    // run n quanta; compare first sample index, first tx index, sampled bit
    task automatic run_span(input logic rx_v, input int n, input int exp_s, input int exp_t,
                            input int exp_b, input string req);
        int fs = -1;
        int ft = -1;
        int fb = -1;
        for (int i = 0; i < n; i++) begin
            logic s, t, b;
            step(rx_v, s, t, b);
            if (s && fs < 0) begin fs = i; fb = int'(b); end
            if (t && ft < 0) ft = i;
        end
        check(fs == exp_s, {req, " sample index"}, fs, exp_s);
        check(ft == exp_t, {req, " tx index"}, ft, exp_t);
        if (exp_b >= 0) check(fb == exp_b, {req, " sampled bit"}, fb, exp_b);
    endtask

    task automatic t_reset();
        do_reset(4'd5, 3'd2, 2'd1, 1'b0);
        @(negedge clk_i);
        check(sample_o == 1'b0, "R1 sample strobe", int'(sample_o), 0);
        check(tx_pt_o == 1'b0, "R1 tx strobe", int'(tx_pt_o), 0);
        check(sample_bit_o == 1'b1, "R1 sampled bit", int'(sample_bit_o), 1);
    endtask

    // R2 R3: 6+3 quanta, bit of 10
    task automatic t_nominal();
        do_reset(4'd5, 3'd2, 2'd1, 1'b0);
        run_span(1'b1, 10, 6, 9, 1, "R3 bit0");
        run_span(1'b1, 10, 6, 9, 1, "R3 bit1");
        do_reset(4'd2, 3'd0, 2'd0, 1'b0);
        run_span(1'b1, 5, 3, 4, 1, "R2 short cfg");
    endtask

    // R4 R8 R10: falling edge in sync, rising edge in sync
    task automatic t_values();
        do_reset(4'd5, 3'd2, 2'd1, 1'b0);
        run_span(1'b1, 10, 6, 9, 1, "R4 first");
        run_span(1'b0, 10, 6, 9, 0, "R8 edge in sync, R4 bit 0");
        run_span(1'b1, 10, 6, 9, 1, "R10 rising edge");
    endtask

    // R5 hard sync in segment 1 and segment 2
    task automatic t_hard();
        do_reset(4'd5, 3'd2, 2'd1, 1'b1);
        run_span(1'b1, 3, -1, -1, -1, "R5 pre");
        run_span(1'b0, 10, 6, 9, 0, "R5 hard sync seg1");
        do_reset(4'd5, 3'd2, 2'd1, 1'b1);
        run_span(1'b1, 8, 6, -1, 1, "R5 pre2");
        run_span(1'b0, 10, 6, 0, 0, "R5 hard sync seg2");
    endtask

    // R6 late edges: capped and uncapped
    task automatic t_late();
        do_reset(4'd5, 3'd2, 2'd1, 1'b0);
        run_span(1'b1, 13, 6, 9, 1, "R6 pre");
        run_span(1'b0, 9, 5, 8, 0, "R6 capped lengthen");
        run_span(1'b1, 1, -1, -1, -1, "R6 sync");
        run_span(1'b0, 10, 6, 9, 0, "R6 one-quantum lengthen");
    endtask

    // R9 second edge ignored
    task automatic t_once();
        do_reset(4'd5, 3'd2, 2'd1, 1'b0);
        run_span(1'b1, 13, 6, 9, 1, "R9 pre");
        run_span(1'b0, 1, -1, -1, -1, "R9 first edge");
        run_span(1'b1, 1, -1, -1, -1, "R9 release");
        run_span(1'b0, 10, 3, 6, 0, "R9 second edge");
    endtask

    // R7 early edges: restart and shorten
    task automatic t_early();
        do_reset(4'd5, 3'd2, 2'd1, 1'b0);
        run_span(1'b1, 8, 6, -1, 1, "R7 pre");
        run_span(1'b0, 10, 6, 0, 0, "R7 restart");
        do_reset(4'd5, 3'd7, 2'd1, 1'b0);
        run_span(1'b1, 8, 6, -1, 1, "R7 pre long");
        run_span(1'b0, 12, 11, 4, 0, "R7 shorten");
    endtask

    logic done = 1'b0;

    initial begin
        t_reset();
        t_nominal();
        t_values();
        t_hard();
        t_late();
        t_once();
        t_early();
        check(stray == 0, "R11 strobes between ticks", stray, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule